// File: doc/BRIEF.md
# Dual-Clock FIFO with Level Flags

This block is a first-in first-out buffer whose write side and read side run on separate clocks. The two clocks may be one shared clock or two unrelated ones. Each side has an active-low enable. A word is stored on every write-clock edge while the write enable is low and the buffer has room. On every read-clock edge while the read enable is low and the buffer holds data, the oldest word moves into a registered data output.

Status comes out on four active-low lines:

- An empty-or-full line.
- A low-or-high occupancy line, which marks the bottom quarter and the top quarter of the buffer.
- A more-than-half line.
- A sticky misuse line. It marks a read of an empty buffer or a write into a full one.

The half of each flag that belongs to the write side is computed on the write clock. The half that belongs to the read side is computed on the read clock. The write and read pointers cross between the two domains as Gray codes through two-flop synchronisers.

An active-low master reset empties the buffer and clears the misuse line. An active-low output enable drives a separate drive-enable output, which tells the pad logic when to put the data bus in a high-impedance state.

Top module: `dcfifo_top`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_en_n` low and the buffer not full, `wr_data` is stored. Holding `wr_en_n` low stores one word per cycle. A write attempted while full stores nothing.
- R2: On a rising `rd_clk` edge with `rd_en_n` low and the buffer not empty, the oldest stored word appears on `rd_data`. Words leave in the order they were written. A read attempted while empty leaves `rd_data` unchanged.
- R3: Once both sides have settled, `ef_n` is 0 exactly when the word count is 0 or equals DEPTH. Otherwise it is 1.
- R4: Once settled, `lvl_n` is 0 when the count is at most DEPTH/4 (zero included). It is also 0 when the count is at least DEPTH-DEPTH/4 (full included). Otherwise it is 1.
- R5: Once settled, `half_n` is 0 exactly when the count is strictly greater than DEPTH/2.
- R6: A read enabled while the buffer is empty drives `fault_n` to 0. It stays 0 until a write makes the buffer non-empty.
- R7: A write enabled while the buffer is full drives `fault_n` to 0. It stays 0 until a read makes the buffer non-full.
- R8: While `mrst_n` is low and after it is released, the buffer is empty and any earlier contents are discarded. After reset, `ef_n`=0, `lvl_n`=0, `half_n`=1, `fault_n`=1 and `rd_data`=0.
- R9: `rd_drive` equals the inverse of `oe_n`, combinationally.
- R10: Ordering and flags hold both with `rd_clk` and `wr_clk` tied together and with unrelated clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | WIDTH | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | WIDTH | Registered output word |
| rd_drive | output | 1 | High when `rd_data` should be driven onto the bus |
| ef_n | output | 1 | Low when empty (read side) or full (write side) |
| lvl_n | output | 1 | Low at or below one quarter (read side) or at or above three quarters (write side) |
| half_n | output | 1 | Low when more than half full (write side) |
| fault_n | output | 1 | Low after a read while empty or a write while full, held until cleared |

## Verification
The assertions check several rules on every clock edge:

- A pointer never moves while its own side reports empty or full.
- The count seen on the write side never exceeds DEPTH.
- Each latched fault only ever coexists with its empty or full condition.
- The output word holds between accepted reads.

Other behaviour can only be shown by the bench's scenarios, because it depends on the contents and on settling across the clock domains:

- Words come out in the order they went in.
- Each flag changes at the right count, walked through every quarter and half boundary in both directions.
- A refused write leaves the contents untouched.
- The fault line releases once the buffer leaves empty or full.
- All of this holds with both a shared clock and unrelated clocks.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    typedef struct packed {
        logic full;
        logic upper;
        logic half;
        logic fault;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic lower;
        logic fault;
    } rd_flags_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 36,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_fire,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_fire,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_fire) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rdata <= '0;
        end else if (rd_fire) begin
            rdata <= store[raddr];
        end
    end

    // R2
    rdata_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_fire |=> (rdata == $past(rdata)));
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic [PW-1:0] rgray_sync,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          wr_fire,
    output wr_flags_t     flags
);
    localparam logic [PW-1:0] FULL_CNT  = PW'(DEPTH);
    localparam logic [PW-1:0] UPPER_CNT = PW'(DEPTH - DEPTH / 4);
    localparam logic [PW-1:0] HALF_CNT  = PW'(DEPTH / 2);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wnext;
    logic [PW-1:0] rbin;
    logic [PW-1:0] cnt_next;
    logic          full_next;

    assign rbin      = PW'(gray_to_bin(32'(rgray_sync)));
    assign wr_fire   = wr_req & ~flags.full;
    assign wnext     = wbin + PW'(wr_fire);
    assign cnt_next  = wnext - rbin;
    assign full_next = (cnt_next == FULL_CNT);
    assign waddr     = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            flags <= '0;
        end else begin
            wbin        <= wnext;
            wgray       <= PW'(bin_to_gray(32'(wnext)));
            flags.full  <= full_next;
            flags.upper <= (cnt_next >= UPPER_CNT);
            flags.half  <= (cnt_next > HALF_CNT);
            flags.fault <= full_next & (flags.fault | (flags.full & wr_req));
        end
    end

    // R1
    wr_hold_full_chk: assert property (@(posedge clk) disable iff (rst)
        flags.full |=> (wbin == $past(wbin)));
    // R3
    wr_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (wbin - rbin) <= FULL_CNT);
    // R7
    wr_fault_full_chk: assert property (@(posedge clk) disable iff (rst)
        flags.fault |-> flags.full);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic [PW-1:0] wgray_sync,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          rd_fire,
    output rd_flags_t     flags
);
    localparam logic [PW-1:0] LOWER_CNT = PW'(DEPTH / 4);

    logic [PW-1:0] rbin;
    logic [PW-1:0] rnext;
    logic [PW-1:0] wbin;
    logic [PW-1:0] cnt_next;
    logic          empty_next;

    assign wbin       = PW'(gray_to_bin(32'(wgray_sync)));
    assign rd_fire    = rd_req & ~flags.empty;
    assign rnext      = rbin + PW'(rd_fire);
    assign cnt_next   = wbin - rnext;
    assign empty_next = (cnt_next == '0);
    assign raddr      = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin        <= '0;
            rgray       <= '0;
            flags.empty <= 1'b1;
            flags.lower <= 1'b1;
            flags.fault <= 1'b0;
        end else begin
            rbin        <= rnext;
            rgray       <= PW'(bin_to_gray(32'(rnext)));
            flags.empty <= empty_next;
            flags.lower <= (cnt_next <= LOWER_CNT);
            flags.fault <= empty_next & (flags.fault | (flags.empty & rd_req));
        end
    end

    // R2
    rd_hold_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flags.empty |=> (rbin == $past(rbin)));
    // R6
    rd_fault_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flags.fault |-> flags.empty);
    // R4
    rd_empty_low_chk: assert property (@(posedge clk) disable iff (rst)
        flags.empty |-> flags.lower);
endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 36
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             mrst_n,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_drive,
    output logic             ef_n,
    output logic             lvl_n,
    output logic             half_n,
    output logic             fault_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_rst;
    logic          rd_rst;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_rs;
    logic [PW-1:0] rgray_ws;
    logic          wr_fire;
    logic          rd_fire;
    wr_flags_t     wfl;
    rd_flags_t     rfl;

    dcfifo_sync #(.W(1)) u_wr_rst (
        .clk(wr_clk), .rst(1'b0), .d(~mrst_n), .q(wr_rst)
    );
    dcfifo_sync #(.W(1)) u_rd_rst (
        .clk(rd_clk), .rst(1'b0), .d(~mrst_n), .q(rd_rst)
    );
    dcfifo_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_ws)
    );
    dcfifo_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_rs)
    );

    dcfifo_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wr_req(~wr_en_n), .rgray_sync(rgray_ws),
        .waddr(waddr), .wgray(wgray), .wr_fire(wr_fire), .flags(wfl)
    );

    dcfifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_req(~rd_en_n), .wgray_sync(wgray_rs),
        .raddr(raddr), .rgray(rgray), .rd_fire(rd_fire), .flags(rfl)
    );

    dcfifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .wr_clk(wr_clk), .wr_fire(wr_fire), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_fire(rd_fire), .raddr(raddr),
        .rdata(rd_data)
    );

    assign rd_drive = ~oe_n;
    assign ef_n     = ~(rfl.empty | wfl.full);
    assign lvl_n    = ~(rfl.lower | wfl.upper);
    assign half_n   = ~wfl.half;
    assign fault_n  = ~(rfl.fault | wfl.fault);

    // R5
    half_needs_room_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wfl.full |-> (wfl.half && wfl.upper));
endmodule

// File: tb/dcfifo_top_bench.sv
`timescale 1ns/1ps
module dcfifo_top_bench;
    localparam int D = 1024;
    localparam int W = 36;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic shared = 1'b0;
    logic wr_clk;
    logic rd_clk;
    logic mrst_n = 1'b0;
    logic wr_en_n = 1'b1;
    logic rd_en_n = 1'b1;
    logic oe_n = 1'b1;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic rd_drive, ef_n, lvl_n, half_n, fault_n;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [W-1:0] mdl[$];
    logic [W-1:0] last_out = '0;
    int wcnt, rcnt;

    always #2.5 clk_a = ~clk_a;
    always #3.5 clk_b = ~clk_b;
    assign wr_clk = clk_a;
    assign rd_clk = shared ? clk_a : clk_b;

    dcfifo_top #(.DEPTH(D), .WIDTH(W)) u_dcfifo_top (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .wr_en_n(wr_en_n),
        .wr_data(wr_data), .rd_en_n(rd_en_n), .oe_n(oe_n), .rd_data(rd_data),
        .rd_drive(rd_drive), .ef_n(ef_n), .lvl_n(lvl_n), .half_n(half_n),
        .fault_n(fault_n)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd_word();
        return W'({$urandom(), $urandom()});
    endfunction

    function automatic logic exp_ef(int c);  return !(c == 0 || c == D); endfunction
    function automatic logic exp_lvl(int c); return !(c <= D/4 || c >= D - D/4); endfunction
    function automatic logic exp_half(int c); return !(c > D/2); endfunction

    task automatic settle();
        repeat (10) @(negedge rd_clk);
        repeat (10) @(negedge wr_clk);
        @(negedge rd_clk);
    endtask

    task automatic check_flags(int c);
        settle();
        chk($sformatf("R3 ef_n at count %0d", c), ef_n, exp_ef(c));
        chk($sformatf("R4 lvl_n at count %0d", c), lvl_n, exp_lvl(c));
        chk($sformatf("R5 half_n at count %0d", c), half_n, exp_half(c));
    endtask

    task automatic write_n(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en_n = 1'b0;
            wr_data = rnd_word();
            mdl.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic read_n(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            if (i > 0) begin
                last_out = mdl.pop_front();
                chk(req, rd_data, last_out);
            end
            rd_en_n = 1'b0;
        end
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        if (n > 0) begin
            last_out = mdl.pop_front();
            chk(req, rd_data, last_out);
        end
    endtask

    task automatic do_reset();
        wr_en_n = 1'b1;
        rd_en_n = 1'b1;
        mrst_n = 1'b0;
        repeat (8) @(negedge clk_b);
        repeat (8) @(negedge clk_a);
        mrst_n = 1'b1;
        repeat (8) @(negedge clk_b);
        repeat (8) @(negedge clk_a);
        mdl.delete();
        last_out = '0;
    endtask

    task automatic random_phase(int cycles);
        bit pend = 0;
        wcnt = 0;
        rcnt = 0;
        fork
            begin
                repeat (cycles) begin
                    @(negedge wr_clk);
                    if (($urandom() % 3) != 0 && (wcnt - rcnt) < D - 16) begin
                        wr_en_n = 1'b0;
                        wr_data = rnd_word();
                        mdl.push_back(wr_data);
                        wcnt++;
                    end else begin
                        wr_en_n = 1'b1;
                    end
                end
                @(negedge wr_clk);
                wr_en_n = 1'b1;
            end
            begin
                repeat (cycles) begin
                    @(negedge rd_clk);
                    if (pend) begin
                        last_out = mdl.pop_front();
                        chk("R10 order under mixed traffic", rd_data, last_out);
                        pend = 0;
                    end
                    if (($urandom() % 2) != 0 && (wcnt - rcnt) > 16) begin
                        rd_en_n = 1'b0;
                        pend = 1;
                        rcnt++;
                    end else begin
                        rd_en_n = 1'b1;
                    end
                end
                @(negedge rd_clk);
                rd_en_n = 1'b1;
                if (pend) begin
                    last_out = mdl.pop_front();
                    chk("R10 order under mixed traffic", rd_data, last_out);
                end
            end
        join
    endtask

    task automatic run_mode(bit sh);
        int c;
        int up_pts[8] = '{256, 257, 512, 513, 767, 768, 1023, 1024};
        int dn_pts[8] = '{1023, 768, 767, 513, 512, 257, 256, 0};
        shared = sh;
        do_reset();
        // R8: reset state
        chk("R8 ef_n after reset", ef_n, 1'b0);
        chk("R8 lvl_n after reset", lvl_n, 1'b0);
        chk("R8 half_n after reset", half_n, 1'b1);
        chk("R8 fault_n after reset", fault_n, 1'b1);
        chk("R8 rd_data after reset", rd_data, '0);

        // R6: read while empty
        @(negedge rd_clk); rd_en_n = 1'b0;
        @(negedge rd_clk); rd_en_n = 1'b1;
        settle();
        chk("R6 fault_n after empty read", fault_n, 1'b0);
        chk("R2 rd_data unchanged by empty read", rd_data, last_out);
        write_n(1);
        settle();
        chk("R6 fault_n released by write", fault_n, 1'b1);
        c = 1;
        check_flags(c);

        // R1: fill through each boundary
        foreach (up_pts[i]) begin
            write_n(up_pts[i] - c);
            c = up_pts[i];
            check_flags(c);
        end

        // R7: write while full is refused and latched
        @(negedge wr_clk); wr_en_n = 1'b0; wr_data = rnd_word();
        @(negedge wr_clk); wr_en_n = 1'b1;
        settle();
        chk("R7 fault_n after full write", fault_n, 1'b0);
        chk("R3 ef_n still full", ef_n, 1'b0);

        // drain through each boundary, checking order
        foreach (dn_pts[i]) begin
            read_n(c - dn_pts[i], "R2 order on drain");
            c = dn_pts[i];
            check_flags(c);
            if (i == 0) chk("R7 fault_n released by read", fault_n, 1'b1);
        end
        chk("R1 refused word not stored", mdl.size(), 0);

        // R6 again: output holds last word
        @(negedge rd_clk); rd_en_n = 1'b0;
        @(negedge rd_clk); rd_en_n = 1'b1;
        settle();
        chk("R6 fault_n after second empty read", fault_n, 1'b0);
        chk("R2 rd_data holds after empty read", rd_data, last_out);

        // R9
        oe_n = 1'b1; #1;
        chk("R9 rd_drive with oe_n high", rd_drive, 1'b0);
        oe_n = 1'b0; #1;
        chk("R9 rd_drive with oe_n low", rd_drive, 1'b1);

        // R10: mixed traffic, then drain
        random_phase(3000);
        settle();
        read_n(mdl.size(), "R10 order on final drain");
        check_flags(0);

        // R8: reset discards contents
        write_n(40);
        settle();
        do_reset();
        chk("R8 ef_n empty after reset with data", ef_n, 1'b0);
        chk("R8 half_n after reset with data", half_n, 1'b1);
        chk("R8 rd_data cleared by reset", rd_data, '0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd7151));
        run_mode(1'b0);
        run_mode(1'b1);
        finish_run();
    end

    initial begin
        #(150000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule